// File: doc/BRIEF.md
# Split-Transaction Bus Phase Sequencer

This block runs the bus side of one agent on a split-transaction bus. The command/address bus and the data bus are arbitrated separately. The local side hands over one transaction at a time through a valid/ready handshake. There are four transaction kinds: a read-type request, an upgrade, a writeback and a data response. The block then requests the bus it needs and waits for the grant. It steps through the fixed phase cycles, drives the address, tag and data beats, and reports a single commit pulse when the transaction is final.

A request phase runs through five cycles after the grant is seen: the grant (arbitration) cycle, resolution, address, decode and acknowledge. The acknowledge cycle is held for as long as the snoop lookup reports not ready. A data response runs four beats of the line and then a turnaround cycle. It carries the request tag and never touches the address bus. A negative acknowledge inside a phase's window cancels that phase. The block then releases the buses and waits a pseudo-random backoff whose range widens with each consecutive NACK, and retries the same transaction.

Writebacks run a request phase only. They hold both buses and send the line during that phase. Upgrades run a request phase only, and they count as committed at the grant.

Top module: `stb_phase_seq`

## Requirements
- R1: After reset, `txn_ready` is 1 and `abus_req`, `dbus_req`, `a_valid`, `d_valid` and `txn_commit` are 0.
- R2: For a read-type request (kind code 0), if `abus_req` and `abus_gnt` are both high in cycle T, then `a_valid` is high only in cycle T+2, with `a_addr` equal to the accepted address and `a_cmd` equal to the kind code (read 0, upgrade 1, writeback 2, response 3). If `snoop_ready` is high in T+4, `txn_commit` pulses in T+4 and `txn_ready` returns in T+5.
- R3: While `snoop_ready` is low in the acknowledge cycle, that cycle repeats with no commit. The commit comes in the first acknowledge cycle where `snoop_ready` is high.
- R4: `a_nack` in the address, decode or acknowledge cycle of a non-upgrade request cancels the phase. There is no commit, and all bus requests and drives are low in the next cycle. The block then re-arbitrates and re-issues the same address, and the retried phase can commit.
- R5: After the n-th consecutive cancel, the number of cycles with no bus request before the next request lies in 1..2^min(n,4)-1. This is exactly 1 for the first cancel. The count of consecutive cancels restarts at every commit.
- R6: A NACK in the grant or resolution cycle of a request has no effect: the phase proceeds and commits on time.
- R7: A writeback (kind 2) raises both `abus_req` and `dbus_req`. It proceeds only in a cycle where both grants are high. It drives beats 0..3 with its tag on `d_data`/`d_tag` in T+1..T+4, and nothing on the data bus during a stretched acknowledge. Either `a_nack` or `d_nack` in its address, decode or acknowledge cycle cancels it.
- R8: An upgrade (kind 1) pulses `txn_commit` in its grant cycle and never raises `dbus_req`. A NACK later in its phase is ignored: no backoff and no second commit.
- R9: A data response (kind 3) raises only `dbus_req`. After a grant in cycle T, it drives beat k (bits k*W up to k*W+W-1 of `txn_data`) with its tag in T+1+k, for k = 0..3. It has `d_valid` low in T+5, never drives `a_valid`, and commits in T+5. `d_nack` in T+1..T+5 cancels it, and the retry starts again from beat 0.
- R10: If a NACK and `snoop_ready` are both high in the same acknowledge cycle, the NACK wins: no commit, and the phase is cancelled.
- R11: The fields of a transaction are captured at acceptance. `txn_ready` stays low until the cycle after its commit, and input changes after acceptance do not alter what is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_valid | input | 1 | Local transaction offered |
| txn_ready | output | 1 | Sequencer idle, can accept |
| txn_kind | input | 2 | 0 read, 1 upgrade, 2 writeback, 3 data response |
| txn_addr | input | AW | Line address of the transaction |
| txn_tag | input | TAG_W | Tag sent with data beats |
| txn_data | input | BEATS*BEAT_W | Line data, beat k in slice k |
| txn_commit | output | 1 | One-cycle pulse when the transaction is final |
| abus_req | output | 1 | Arbitration request, address bus |
| abus_gnt | input | 1 | Grant, address bus |
| dbus_req | output | 1 | Arbitration request, data bus |
| dbus_gnt | input | 1 | Grant, data bus |
| a_valid | output | 1 | Address cycle being driven |
| a_cmd | output | 2 | Command code in the address cycle |
| a_addr | output | AW | Address in the address cycle |
| snoop_ready | input | 1 | Snoop lookup finished; ends acknowledge |
| a_nack | input | 1 | Negative acknowledge, address bus |
| d_nack | input | 1 | Negative acknowledge, data bus |
| d_valid | output | 1 | Data beat being driven |
| d_tag | output | TAG_W | Tag on the data bus |
| d_data | output | BEAT_W | Data beat |

## Verification
Cancellation and completion can fall in the same acknowledge cycle. A NACK and `snoop_ready` can both be high in it, and only the NACK may take effect. A retry also shares its first cycle with the end of the backoff count. The bench drives both in one acknowledge cycle, and separately a NACK in the turnaround of a response. It judges the outcome from the ports: there is no commit pulse, the request is withdrawn in the next cycle, and the gap before the next request stays within the range for that many consecutive cancels.

// File: rtl/stb_pkg.sv
package stb_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ARB,
    ST_RES,
    ST_ADDR,
    ST_DEC,
    ST_ACK,
    ST_DARB,
    ST_BEAT,
    ST_TURN,
    ST_BACK
  } stb_state_e;

  localparam logic [1:0] KIND_READ = 2'd0;
  localparam logic [1:0] KIND_UPG  = 2'd1;
  localparam logic [1:0] KIND_WB   = 2'd2;
  localparam logic [1:0] KIND_RESP = 2'd3;

  // cycles of a request phase in which a NACK is honoured
  function automatic logic in_req_window(stb_state_e s);
    return (s == ST_ADDR) || (s == ST_DEC) || (s == ST_ACK);
  endfunction

  // request-phase cycles after the grant in which a writeback streams data
  function automatic logic in_wb_stream(stb_state_e s);
    return (s == ST_RES) || (s == ST_ADDR) || (s == ST_DEC) || (s == ST_ACK);
  endfunction

endpackage

// File: rtl/stb_backoff.sv
module stb_backoff #(
  parameter int LFSR_W = 4,
  parameter int CAP    = 4,
  parameter int SEED   = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cancel,
  input  logic clear,
  output logic expire
);
  localparam int NCW = $clog2(CAP + 1);
  localparam logic [LFSR_W:0] ONE = (LFSR_W + 1)'(1);

  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] wait_q;
  logic [NCW-1:0]    run_q;
  logic [NCW-1:0]    run_nx;

  // backoff length: random bits masked to a window of 2^run-1, never zero
  function automatic logic [LFSR_W-1:0] bo_len(logic [LFSR_W-1:0] rnd, logic [NCW-1:0] run);
    logic [LFSR_W:0]   span;
    logic [LFSR_W-1:0] pick;
    span = (ONE << run) - ONE;
    pick = rnd & span[LFSR_W-1:0];
    return (pick == '0) ? LFSR_W'(1) : pick;
  endfunction

  assign run_nx = (run_q == NCW'(CAP)) ? run_q : run_q + NCW'(1);
  assign expire = (wait_q == LFSR_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q <= LFSR_W'(SEED);
      wait_q <= '0;
      run_q  <= '0;
    end else begin
      lfsr_q <= {lfsr_q[LFSR_W-2:0], lfsr_q[LFSR_W-1] ^ lfsr_q[LFSR_W-2]};
      if (cancel) begin
        wait_q <= bo_len(lfsr_q, run_nx);
      end else if (wait_q != '0) begin
        wait_q <= wait_q - LFSR_W'(1);
      end
      if (clear) begin
        run_q <= '0;
      end else if (cancel) begin
        run_q <= run_nx;
      end
    end
  end

endmodule

// File: rtl/stb_phase_ctrl.sv
module stb_phase_ctrl
  import stb_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int CW = $clog2(BEATS) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txn_valid,
  input  logic [1:0] txn_kind,
  input  logic [1:0] kind_q,
  input  logic       abus_gnt,
  input  logic       dbus_gnt,
  input  logic       a_nack,
  input  logic       d_nack,
  input  logic       snoop_ready,
  input  logic       bo_expire,
  output logic       txn_ready,
  output logic       abus_req,
  output logic       dbus_req,
  output logic       a_valid,
  output logic       d_valid,
  output logic [CW-1:0] beat_idx,
  output logic       ev_commit,
  output logic       ev_cancel
);
  stb_state_e st_q, st_nx;
  logic [CW-1:0] cnt_q;
  logic is_wb, is_upg, is_resp, both_gnt, req_nack, last_beat;

  assign is_wb     = (kind_q == KIND_WB);
  assign is_upg    = (kind_q == KIND_UPG);
  assign is_resp   = (kind_q == KIND_RESP);
  assign both_gnt  = abus_gnt && (!is_wb || dbus_gnt);
  assign req_nack  = !is_upg && (a_nack || (is_wb && d_nack));
  assign last_beat = (cnt_q == CW'(BEATS - 1));

  // cancel event: a NACK inside the window of the current phase
  assign ev_cancel = (in_req_window(st_q) && req_nack) ||
                     (((st_q == ST_BEAT) || (st_q == ST_TURN)) && d_nack);

  // commit event: upgrade at grant, request at acknowledge end, response at turnaround
  assign ev_commit = ((st_q == ST_ARB) && is_upg && abus_gnt) ||
                     ((st_q == ST_ACK) && !is_upg && snoop_ready && !ev_cancel) ||
                     ((st_q == ST_TURN) && !ev_cancel);

  assign txn_ready = (st_q == ST_IDLE);
  assign abus_req  = (st_q == ST_ARB);
  assign dbus_req  = ((st_q == ST_ARB) && is_wb) || (st_q == ST_DARB);
  assign a_valid   = (st_q == ST_ADDR);
  assign d_valid   = (st_q == ST_BEAT) ||
                     (is_wb && in_wb_stream(st_q) && (cnt_q < CW'(BEATS)));
  assign beat_idx  = cnt_q;

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      ST_IDLE: if (txn_valid) st_nx = (txn_kind == KIND_RESP) ? ST_DARB : ST_ARB;
      ST_ARB:  if (both_gnt) st_nx = ST_RES;
      ST_RES:  st_nx = ST_ADDR;
      ST_ADDR: st_nx = ev_cancel ? ST_BACK : ST_DEC;
      ST_DEC:  st_nx = ev_cancel ? ST_BACK : ST_ACK;
      ST_ACK:  begin
        if (ev_cancel)        st_nx = ST_BACK;
        else if (snoop_ready) st_nx = ST_IDLE;
      end
      ST_DARB: if (dbus_gnt) st_nx = ST_BEAT;
      ST_BEAT: begin
        if (ev_cancel)      st_nx = ST_BACK;
        else if (last_beat) st_nx = ST_TURN;
      end
      ST_TURN: st_nx = ev_cancel ? ST_BACK : ST_IDLE;
      ST_BACK: if (bo_expire) st_nx = is_resp ? ST_DARB : ST_ARB;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_nx;
      if ((st_q == ST_ARB) || (st_q == ST_DARB)) begin
        cnt_q <= '0;
      end else if (d_valid) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

endmodule

// File: rtl/stb_phase_seq.sv
module stb_phase_seq
  import stb_pkg::*;
#(
  parameter int AW        = 40,
  parameter int TAG_W     = 3,
  parameter int BEAT_W    = 256,
  parameter int BEATS     = 4,
  parameter int LFSR_W    = 4,
  parameter int BO_CAP    = 4,
  parameter int LFSR_SEED = 9,
  localparam int LINE_W   = BEATS * BEAT_W,
  localparam int CW       = $clog2(BEATS) + 1,
  localparam int IW       = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_valid,
  output logic              txn_ready,
  input  logic [1:0]        txn_kind,
  input  logic [AW-1:0]     txn_addr,
  input  logic [TAG_W-1:0]  txn_tag,
  input  logic [LINE_W-1:0] txn_data,
  output logic              txn_commit,
  output logic              abus_req,
  input  logic              abus_gnt,
  output logic              dbus_req,
  input  logic              dbus_gnt,
  output logic              a_valid,
  output logic [1:0]        a_cmd,
  output logic [AW-1:0]     a_addr,
  input  logic              snoop_ready,
  input  logic              a_nack,
  input  logic              d_nack,
  output logic              d_valid,
  output logic [TAG_W-1:0]  d_tag,
  output logic [BEAT_W-1:0] d_data
);
  logic [1:0]        kind_q;
  logic [AW-1:0]     addr_q;
  logic [TAG_W-1:0]  tag_q;
  logic [LINE_W-1:0] data_q;
  logic [CW-1:0]     beat_idx;
  logic              ev_commit, ev_cancel, bo_expire, accept;
  logic [BEAT_W-1:0] beat_w [BEATS];

  assign accept = txn_valid && txn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= KIND_READ;
      addr_q <= '0;
      tag_q  <= '0;
      data_q <= '0;
    end else if (accept) begin
      kind_q <= txn_kind;
      addr_q <= txn_addr;
      tag_q  <= txn_tag;
      data_q <= txn_data;
    end
  end

  stb_phase_ctrl #(.BEATS(BEATS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .txn_valid  (txn_valid),
    .txn_kind   (txn_kind),
    .kind_q     (kind_q),
    .abus_gnt   (abus_gnt),
    .dbus_gnt   (dbus_gnt),
    .a_nack     (a_nack),
    .d_nack     (d_nack),
    .snoop_ready(snoop_ready),
    .bo_expire  (bo_expire),
    .txn_ready  (txn_ready),
    .abus_req   (abus_req),
    .dbus_req   (dbus_req),
    .a_valid    (a_valid),
    .d_valid    (d_valid),
    .beat_idx   (beat_idx),
    .ev_commit  (ev_commit),
    .ev_cancel  (ev_cancel)
  );

  stb_backoff #(.LFSR_W(LFSR_W), .CAP(BO_CAP), .SEED(LFSR_SEED)) u_backoff (
    .clk   (clk),
    .rst_n (rst_n),
    .cancel(ev_cancel),
    .clear (ev_commit),
    .expire(bo_expire)
  );

  for (genvar g = 0; g < BEATS; g++) begin : g_beat
    assign beat_w[g] = data_q[g*BEAT_W +: BEAT_W];
  end

  assign txn_commit = ev_commit;
  assign a_cmd      = a_valid ? kind_q : 2'd0;
  assign a_addr     = a_valid ? addr_q : '0;
  assign d_tag      = d_valid ? tag_q : '0;
  assign d_data     = d_valid ? beat_w[beat_idx[IW-1:0]] : '0;

endmodule

// File: rtl/stb_phase_seq_chk.sv
module stb_phase_seq_chk #(
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txn_ready,
  input logic             txn_commit,
  input logic             abus_req,
  input logic             abus_gnt,
  input logic             dbus_req,
  input logic             a_valid,
  input logic             d_valid,
  input logic [TAG_W-1:0] d_tag,
  input logic             ev_cancel
);

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    txn_ready |-> (!abus_req && !dbus_req && !a_valid && !d_valid));

  p_addr_after_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_valid) |-> $past(abus_req && abus_gnt, 2));

  p_addr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid |=> !a_valid);

  p_release_on_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cancel |=> (!abus_req && !dbus_req && !a_valid && !d_valid));

  p_nack_beats_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_cancel && txn_commit));

  p_tag_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && $past(d_valid)) |-> $stable(d_tag));

endmodule

bind stb_phase_seq stb_phase_seq_chk #(.TAG_W(TAG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .txn_ready (txn_ready),
  .txn_commit(txn_commit),
  .abus_req  (abus_req),
  .abus_gnt  (abus_gnt),
  .dbus_req  (dbus_req),
  .a_valid   (a_valid),
  .d_valid   (d_valid),
  .d_tag     (d_tag),
  .ev_cancel (ev_cancel)
);

// File: tb/stb_phase_seq_tb.sv
module stb_phase_seq_tb;
  localparam int CLK_P = 10;
  localparam int AW    = 40;
  localparam int TW    = 3;
  localparam int BW    = 256;
  localparam int NB    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txn_valid = 1'b0;
  logic txn_ready;
  logic [1:0] txn_kind = 2'd0;
  logic [AW-1:0] txn_addr = '0;
  logic [TW-1:0] txn_tag = '0;
  logic [NB*BW-1:0] txn_data = '0;
  logic txn_commit, abus_req, dbus_req, a_valid, d_valid;
  logic abus_gnt = 1'b0, dbus_gnt = 1'b0;
  logic snoop_ready = 1'b0, a_nack = 1'b0, d_nack = 1'b0;
  logic [1:0] a_cmd;
  logic [AW-1:0] a_addr;
  logic [TW-1:0] d_tag;
  logic [BW-1:0] d_data;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  stb_phase_seq u_dut (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_kind(txn_kind), .txn_addr(txn_addr), .txn_tag(txn_tag), .txn_data(txn_data),
    .txn_commit(txn_commit), .abus_req(abus_req), .abus_gnt(abus_gnt),
    .dbus_req(dbus_req), .dbus_gnt(dbus_gnt), .a_valid(a_valid), .a_cmd(a_cmd),
    .a_addr(a_addr), .snoop_ready(snoop_ready), .a_nack(a_nack), .d_nack(d_nack),
    .d_valid(d_valid), .d_tag(d_tag), .d_data(d_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic nxt;
    @(posedge clk);
    #1;
  endtask

  task automatic smp;
    @(negedge clk);
  endtask

  function automatic logic [NB*BW-1:0] mkline(input int seed);
    logic [NB*BW-1:0] v;
    for (int k = 0; k < NB; k++) v[k*BW +: BW] = {8{32'(seed * 16 + k)}};
    return v;
  endfunction

  function automatic logic [BW-1:0] slice(input logic [NB*BW-1:0] v, input int k);
    return v[k*BW +: BW];
  endfunction

  // offer one transaction in the current cycle; return in the cycle after acceptance
  task automatic offer(input logic [1:0] kind, input logic [AW-1:0] addr,
                       input logic [TW-1:0] tag, input logic [NB*BW-1:0] line);
    txn_valid = 1'b1; txn_kind = kind; txn_addr = addr; txn_tag = tag; txn_data = line;
    smp;
    chk("R11", "ready before accept", txn_ready, 1);
    nxt;
    txn_valid = 1'b0;
    txn_addr = ~addr;
    txn_tag = ~tag;
    txn_data = ~line;
    txn_kind = 2'd0;
  endtask

  // count request-free cycles after a cancel; ends in the cycle a request is up
  task automatic measure(output int n);
    n = 0;
    smp;
    while (!abus_req && !dbus_req && n < 40) begin
      n++;
      nxt;
      smp;
    end
  endtask

  // from an arbitration cycle with request up: grant, run to acknowledge, commit
  task automatic finish_req(input string req, input logic both);
    abus_gnt = 1'b1; dbus_gnt = both;
    nxt; abus_gnt = 1'b0; dbus_gnt = 1'b0;
    nxt; nxt; nxt;
    snoop_ready = 1'b1;
    smp;
    chk(req, "retry commit", txn_commit, 1);
    nxt; snoop_ready = 1'b0;
  endtask

  task automatic t_reset;
    smp;
    chk("R1", "txn_ready", txn_ready, 1);
    chk("R1", "abus_req", abus_req, 0);
    chk("R1", "dbus_req", dbus_req, 0);
    chk("R1", "a_valid", a_valid, 0);
    chk("R1", "d_valid", d_valid, 0);
    chk("R1", "commit", txn_commit, 0);
    nxt;
  endtask

  task automatic t_read;
    offer(2'd0, 40'h12_3456_7800, 3'd1, mkline(1));
    abus_gnt = 1'b1;
    smp;
    chk("R2", "abus_req at grant", abus_req, 1);
    chk("R11", "ready low after accept", txn_ready, 0);
    nxt; abus_gnt = 1'b0;
    smp; chk("R2", "no addr in resolution", a_valid, 0);
    nxt;
    smp;
    chk("R2", "a_valid T+2", a_valid, 1);
    chk("R11", "captured address", a_addr, 40'h12_3456_7800);
    chk("R2", "a_cmd read", a_cmd, 0);
    nxt;
    smp; chk("R2", "a_valid one cycle", a_valid, 0);
    nxt; snoop_ready = 1'b1;
    smp; chk("R2", "commit T+4", txn_commit, 1);
    nxt; snoop_ready = 1'b0;
    smp;
    chk("R2", "ready T+5", txn_ready, 1);
    chk("R2", "single commit", txn_commit, 0);
  endtask

  task automatic t_stretch;
    offer(2'd0, 40'h00_0000_4440, 3'd2, mkline(2));
    abus_gnt = 1'b1; nxt; abus_gnt = 1'b0;
    nxt; nxt; nxt;
    smp; chk("R3", "no commit while lookup busy", txn_commit, 0);
    nxt;
    smp;
    chk("R3", "ack held, no commit", txn_commit, 0);
    chk("R3", "ack held, not ready", txn_ready, 0);
    nxt; snoop_ready = 1'b1;
    smp; chk("R3", "commit when lookup done", txn_commit, 1);
    nxt; snoop_ready = 1'b0;
    smp; chk("R3", "ready after stretch", txn_ready, 1);
  endtask

  task automatic t_nack_backoff;
    int n;
    offer(2'd0, 40'h00_0000_A200, 3'd3, mkline(3));
    abus_gnt = 1'b1; nxt; abus_gnt = 1'b0;
    nxt; a_nack = 1'b1;
    smp; chk("R4", "nack in address cycle: no commit", txn_commit, 0);
    nxt; a_nack = 1'b0;
    measure(n);
    chk("R5", "first backoff exactly 1", n, 1);
    abus_gnt = 1'b1; nxt; abus_gnt = 1'b0;
    nxt;
    smp;
    chk("R4", "retry a_valid", a_valid, 1);
    chk("R4", "retry same address", a_addr, 40'h00_0000_A200);
    nxt; a_nack = 1'b1;
    smp; chk("R4", "nack in decode: no commit", txn_commit, 0);
    nxt; a_nack = 1'b0;
    measure(n);
    chk("R5", "second backoff within 1..3", (n >= 1 && n <= 3), 1);
    abus_gnt = 1'b1; nxt; abus_gnt = 1'b0;
    nxt; nxt; nxt;
    a_nack = 1'b1; snoop_ready = 1'b1;
    smp; chk("R10", "nack beats snoop_ready", txn_commit, 0);
    nxt; a_nack = 1'b0; snoop_ready = 1'b0;
    measure(n);
    chk("R5", "third backoff within 1..7", (n >= 1 && n <= 7), 1);
    finish_req("R4", 1'b0);
    smp; chk("R4", "ready after retry commit", txn_ready, 1);
    nxt;
    offer(2'd0, 40'h00_0000_B300, 3'd4, mkline(4));
    abus_gnt = 1'b1; nxt; abus_gnt = 1'b0;
    nxt; a_nack = 1'b1;
    nxt; a_nack = 1'b0;
    measure(n);
    chk("R5", "run count cleared by commit", n, 1);
    finish_req("R4", 1'b0);
  endtask

  task automatic t_nack_outside;
    offer(2'd0, 40'h00_0000_C100, 3'd0, mkline(5));
    abus_gnt = 1'b1; a_nack = 1'b1;
    nxt; abus_gnt = 1'b0;
    nxt; a_nack = 1'b0;
    smp; chk("R6", "address cycle still follows", a_valid, 1);
    nxt; nxt; snoop_ready = 1'b1;
    smp; chk("R6", "commit on time", txn_commit, 1);
    nxt; snoop_ready = 1'b0;
  endtask

  task automatic t_writeback;
    int n;
    logic [NB*BW-1:0] line;
    line = mkline(6);
    offer(2'd2, 40'h00_0000_D000, 3'd6, line);
    abus_gnt = 1'b1;
    smp;
    chk("R7", "abus_req", abus_req, 1);
    chk("R7", "dbus_req", dbus_req, 1);
    nxt; dbus_gnt = 1'b1;
    smp;
    chk("R7", "waits for both grants", abus_req, 1);
    chk("R7", "no data before grant pair", d_valid, 0);
    nxt; abus_gnt = 1'b0; dbus_gnt = 1'b0;
    for (int k = 0; k < NB; k++) begin
      smp;
      chk("R7", "wb beat valid", d_valid, 1);
      chk("R7", "wb beat data", d_data, slice(line, k));
      chk("R7", "wb tag", d_tag, 3'd6);
      if (k == 1) chk("R7", "wb a_cmd", a_cmd, 2);
      if (k < NB - 1) nxt;
    end
    chk("R3", "wb ack stretch no commit", txn_commit, 0);
    nxt; snoop_ready = 1'b1;
    smp;
    chk("R7", "no data in stretched ack", d_valid, 0);
    chk("R7", "wb commit", txn_commit, 1);
    nxt; snoop_ready = 1'b0;
    offer(2'd2, 40'h00_0000_D040, 3'd7, line);
    abus_gnt = 1'b1; dbus_gnt = 1'b1;
    nxt; abus_gnt = 1'b0; dbus_gnt = 1'b0;
    nxt; nxt; d_nack = 1'b1;
    smp; chk("R7", "d_nack cancels wb", txn_commit, 0);
    nxt; d_nack = 1'b0;
    measure(n);
    chk("R7", "wb retried after backoff", n, 1);
    chk("R7", "wb retry holds both requests", dbus_req, 1);
    finish_req("R7", 1'b1);
  endtask

  task automatic t_upgrade;
    offer(2'd1, 40'h00_0000_E000, 3'd2, mkline(7));
    abus_gnt = 1'b1;
    smp;
    chk("R8", "commit at grant", txn_commit, 1);
    chk("R8", "no data bus request", dbus_req, 0);
    nxt; abus_gnt = 1'b0;
    smp; chk("R8", "single commit", txn_commit, 0);
    nxt; a_nack = 1'b1;
    smp; chk("R8", "upgrade a_cmd", a_cmd, 1);
    nxt; a_nack = 1'b0;
    nxt; snoop_ready = 1'b1;
    smp;
    chk("R8", "nack ignored: no re-request", abus_req, 0);
    chk("R8", "no second commit", txn_commit, 0);
    nxt; snoop_ready = 1'b0;
    smp; chk("R8", "ready after upgrade", txn_ready, 1);
  endtask

  task automatic t_response;
    int n;
    logic [NB*BW-1:0] line;
    line = mkline(9);
    offer(2'd3, 40'h00_0000_F000, 3'd5, line);
    dbus_gnt = 1'b1;
    smp;
    chk("R9", "dbus_req", dbus_req, 1);
    chk("R9", "no abus_req", abus_req, 0);
    nxt; dbus_gnt = 1'b0;
    for (int k = 0; k < NB; k++) begin
      smp;
      chk("R9", "beat valid", d_valid, 1);
      chk("R9", "beat data", d_data, slice(line, k));
      chk("R9", "tag", d_tag, 3'd5);
      chk("R9", "no address cycle", a_valid, 0);
      nxt;
    end
    smp;
    chk("R9", "turnaround idle", d_valid, 0);
    chk("R9", "commit at turnaround", txn_commit, 1);
    nxt;
    smp; chk("R9", "ready after response", txn_ready, 1);
    nxt;
    offer(2'd3, 40'h0, 3'd4, line);
    dbus_gnt = 1'b1; nxt; dbus_gnt = 1'b0;
    nxt; nxt; nxt; nxt;
    d_nack = 1'b1;
    smp; chk("R9", "d_nack at turnaround: no commit", txn_commit, 0);
    nxt; d_nack = 1'b0;
    measure(n);
    chk("R9", "response re-request", n, 1);
    dbus_gnt = 1'b1; nxt; dbus_gnt = 1'b0;
    smp;
    chk("R9", "retry restarts at beat 0", d_data, slice(line, 0));
    chk("R9", "retry tag", d_tag, 3'd4);
    nxt; nxt; nxt; nxt;
    smp; chk("R9", "retry commit", txn_commit, 1);
    nxt;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_read;
    nxt;
    t_stretch;
    nxt;
    t_nack_backoff;
    t_nack_outside;
    t_writeback;
    t_upgrade;
    nxt;
    t_response;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule